// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns two phase inputs from an incremental encoder into a 16-bit position count. The count wraps between zero and a programmable modulo value. Two encodings are supported. In phase mode, every valid single-bit step of the 2-bit Gray sequence on A/B moves the count by one, which gives four counts per encoder cycle. In count-and-direction mode, a rising edge on phase A moves the count by one, and phase B gives the direction.

Both phase inputs pass through two synchronizing flops. A small state machine then tracks the last phase pair and emits one-cycle step pulses. The counter reports the direction of its most recent step and raises a sticky overflow flag whenever it wraps. It also records whether the latest wrap happened at the top or at the bottom of the range. A one-cycle clear strobe clears the overflow flag.

The decoder state machine has four states, one for each phase pair {A,B}: `PH_00`, `PH_01`, `PH_11` and `PH_10`. Every cycle it moves to the state that matches the synchronized input.
- In phase mode, these transitions are up steps: `PH_00→PH_01`, `PH_01→PH_11`, `PH_11→PH_10` and `PH_10→PH_00`.
- Their reverses are down steps.
- The transitions `PH_00↔PH_11` and `PH_01↔PH_10` are invalid jumps and produce no step.
- In count-and-direction mode, a transition from a state with A=0 to a state with A=1 is a step. It is an up step when B=1 and a down step when B=0.

Top module: `qdec_position_counter`

## Requirements
- R1: While `enable` is 0, phase activity has no effect: `count`, `dir_up`, `ovf_flag` and `ovf_at_top` hold their values.
- R2: With `mode`=0 (phase encoding), the {A,B} sequence 00→01→11→10→00 adds one to the count per transition, and the reverse sequence subtracts one per transition.
- R3: With `mode`=0, a jump that changes both phase bits at once (00↔11, 01↔10) leaves the count unchanged.
- R4: With `mode`=1 (count and direction), each rising edge of A adds one when B is 1 and subtracts one when B is 0. A falling edge of A has no effect.
- R5: `dir_up` reads 1 after an up step and 0 after a down step.
- R6: An up step taken while `count` is greater than or equal to `modulo` sets `count` to 0, sets `ovf_flag` and sets `ovf_at_top` to 1.
- R7: A down step taken while `count` is 0 sets `count` to `modulo`, sets `ovf_flag` and sets `ovf_at_top` to 0.
- R8: A cycle with `ovf_clear`=1 clears `ovf_flag` at the next edge, unless a wrap happens in that same cycle. `ovf_at_top` is not changed by the clear.
- R9: A phase change applied between clock edges is reflected in `count` at the third rising edge after it, and not earlier.
- R10: After reset, `count`=0, `ovf_flag`=0, `ovf_at_top`=0 and `dir_up`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Decoding enable |
| mode | input | 1 | 0 = phase encoding, 1 = count and direction |
| modulo | input | 16 | Upper bound of the count range |
| phase_a | input | 1 | Asynchronous phase A input |
| phase_b | input | 1 | Asynchronous phase B input |
| ovf_clear | input | 1 | Clear strobe for the overflow flag |
| count | output | 16 | Position count |
| dir_up | output | 1 | Direction of the last step (1 = increment) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_at_top | output | 1 | 1 if the last wrap was at the top, 0 if at the bottom |

## Verification
The timing chain for a phase change is as follows:
- It passes two synchronizing flops.
- It is compared with the decoder state.
- It is applied to `count`, `dir_up` and the overflow status at the third rising edge.

A clear strobe takes effect at the first edge. The bench drives every stimulus just after a falling edge. It waits exactly the number of rising edges due for each result and samples on the next falling edge. One check samples after only two edges to confirm that the count has not yet moved.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_st_t;

    typedef enum logic {
        ENC_PHASE   = 1'b0,
        ENC_CNT_DIR = 1'b1
    } enc_mode_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din[i]};
            end
            assign dout[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/qdec_step_fsm.sv
module qdec_step_fsm
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mode,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn
);
    phase_st_t cur_st;
    phase_st_t nxt_st;
    logic      up_raw;
    logic      dn_raw;

    assign nxt_st = phase_st_t'({ph_a, ph_b});

    // State register: always tracks the synchronized input pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= PH_00;
        else        cur_st <= nxt_st;
    end

    // Output process: classify the transition cur_st -> nxt_st
    always_comb begin
        up_raw = 1'b0;
        dn_raw = 1'b0;
        if (enc_mode_t'(mode) == ENC_CNT_DIR) begin
            if (!cur_st[1] && ph_a) begin
                up_raw = ph_b;
                dn_raw = !ph_b;
            end
        end else begin
            unique case (cur_st)
                PH_00: begin
                    up_raw = (nxt_st == PH_01);
                    dn_raw = (nxt_st == PH_10);
                end
                PH_01: begin
                    up_raw = (nxt_st == PH_11);
                    dn_raw = (nxt_st == PH_00);
                end
                PH_11: begin
                    up_raw = (nxt_st == PH_10);
                    dn_raw = (nxt_st == PH_01);
                end
                PH_10: begin
                    up_raw = (nxt_st == PH_00);
                    dn_raw = (nxt_st == PH_11);
                end
                default: begin
                    up_raw = 1'b0;
                    dn_raw = 1'b0;
                end
            endcase
        end
    end

    assign step_up = enable && up_raw;
    assign step_dn = enable && dn_raw;
endmodule

// File: rtl/qdec_wrap_counter.sv
module qdec_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [CNT_W-1:0] modulo,
    input  logic             ovf_clear,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             ovf_flag,
    output logic             ovf_at_top
);
    logic wrap_top;
    logic wrap_bot;

    assign wrap_top = step_up && (count >= modulo);
    assign wrap_bot = step_dn && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            dir_up     <= 1'b1;
            ovf_flag   <= 1'b0;
            ovf_at_top <= 1'b0;
        end else begin
            if (step_up) begin
                dir_up <= 1'b1;
                count  <= wrap_top ? '0 : count + 1'b1;
            end else if (step_dn) begin
                dir_up <= 1'b0;
                count  <= wrap_bot ? modulo : count - 1'b1;
            end
            if (wrap_top || wrap_bot) begin
                ovf_flag   <= 1'b1;
                ovf_at_top <= wrap_top;
            end else if (ovf_clear) begin
                ovf_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qdec_position_counter.sv
module qdec_position_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode,
    input  logic [CNT_W-1:0] modulo,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             ovf_clear,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             ovf_flag,
    output logic             ovf_at_top
);
    localparam int PH_W = 2;

    logic [PH_W-1:0] ph_sync;
    logic            step_up;
    logic            step_dn;

    qdec_sync #(.WIDTH(PH_W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({phase_a, phase_b}),
        .dout (ph_sync)
    );

    qdec_step_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .mode   (mode),
        .ph_a   (ph_sync[1]),
        .ph_b   (ph_sync[0]),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    qdec_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .modulo    (modulo),
        .ovf_clear (ovf_clear),
        .count     (count),
        .dir_up    (dir_up),
        .ovf_flag  (ovf_flag),
        .ovf_at_top(ovf_at_top)
    );
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] modulo,
    input logic             ovf_clear,
    input logic             step_up,
    input logic             step_dn,
    input logic [CNT_W-1:0] count,
    input logic             dir_up,
    input logic             ovf_flag,
    input logic             ovf_at_top
);
    // R1
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(count) && $stable(ovf_flag) && $stable(dir_up)));

    // R2
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    // R5
    dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> dir_up);

    // R5
    dir_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |=> !dir_up);

    // R6
    top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && count >= modulo) |=> (count == '0 && ovf_flag && ovf_at_top));

    // R7
    bottom_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && count == '0) |=> (count == $past(modulo) && ovf_flag && !ovf_at_top));

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clear && !(step_up && count >= modulo) && !(step_dn && count == '0))
        |=> (!ovf_flag && $stable(ovf_at_top)));
endmodule

bind qdec_position_counter qdec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .modulo    (modulo),
    .ovf_clear (ovf_clear),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .count     (count),
    .dir_up    (dir_up),
    .ovf_flag  (ovf_flag),
    .ovf_at_top(ovf_at_top)
);

// File: tb/tb_qdec_position_counter.sv
`timescale 1ns/1ps
module tb_qdec_position_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] modulo = 16'd5;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        ovf_clear = 1'b0;
    logic [15:0] count;
    logic        dir_up;
    logic        ovf_flag;
    logic        ovf_at_top;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] exp_count = '0;
    logic        exp_dir = 1'b1;
    logic        exp_flag = 1'b0;
    logic        exp_top = 1'b0;

    always #2.5 clk = ~clk;

    qdec_position_counter dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .modulo(modulo),
        .phase_a(phase_a), .phase_b(phase_b), .ovf_clear(ovf_clear),
        .count(count), .dir_up(dir_up), .ovf_flag(ovf_flag), .ovf_at_top(ovf_at_top)
    );

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "count", count, exp_count);
        check(req, "dir_up", {15'd0, dir_up}, {15'd0, exp_dir});
        check(req, "ovf_flag", {15'd0, ovf_flag}, {15'd0, exp_flag});
        check(req, "ovf_at_top", {15'd0, ovf_at_top}, {15'd0, exp_top});
    endtask

    // drive after a falling edge, result due at third rising edge (R9)
    task automatic drive(logic a, logic b);
        @(negedge clk);
        phase_a = a;
        phase_b = b;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_up();
        exp_dir = 1'b1;
        if (exp_count >= modulo) begin
            exp_count = '0; exp_flag = 1'b1; exp_top = 1'b1;
        end else exp_count = exp_count + 1'b1;
    endtask

    task automatic model_dn();
        exp_dir = 1'b0;
        if (exp_count == '0) begin
            exp_count = modulo; exp_flag = 1'b1; exp_top = 1'b0;
        end else exp_count = exp_count - 1'b1;
    endtask

    // one Gray step in phase mode
    task automatic gray_step(bit up);
        logic [1:0] cur;
        logic [1:0] nxt;
        cur = {phase_a, phase_b};
        case (cur)
            2'b00: nxt = up ? 2'b01 : 2'b10;
            2'b01: nxt = up ? 2'b11 : 2'b00;
            2'b11: nxt = up ? 2'b10 : 2'b01;
            default: nxt = up ? 2'b00 : 2'b11;
        endcase
        drive(nxt[1], nxt[0]);
        if (up) model_up(); else model_dn();
    endtask

    task automatic t_reset();
        check_all("R10");
    endtask

    task automatic t_disabled();
        enable = 1'b0;
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        check_all("R1");
    endtask

    task automatic t_latency();
        enable = 1'b1;
        mode = 1'b0;
        @(negedge clk);
        phase_a = 1'b0; phase_b = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "count after two edges", count, exp_count);
        @(posedge clk);
        @(negedge clk);
        model_up();
        check("R9", "count after three edges", count, exp_count);
    endtask

    task automatic t_phase_updown();
        for (int i = 0; i < 3; i++) gray_step(1'b1);
        check_all("R2 up");
        check("R5", "dir after up", {15'd0, dir_up}, 16'd1);
        gray_step(1'b0);
        gray_step(1'b0);
        check_all("R2 down");
        check("R5", "dir after down", {15'd0, dir_up}, 16'd0);
    endtask

    task automatic t_invalid();
        logic [1:0] cur;
        cur = {phase_a, phase_b};
        drive(~cur[1], ~cur[0]);
        check_all("R3");
    endtask

    task automatic t_top_wrap();
        while (exp_count != modulo) gray_step(1'b1);
        check("R6", "count at modulo", count, modulo);
        gray_step(1'b1);
        check_all("R6");
        check("R6", "top flag", {15'd0, ovf_at_top}, 16'd1);
    endtask

    task automatic t_clear();
        @(negedge clk);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        exp_flag = 1'b0;
        check_all("R8");
    endtask

    task automatic t_bottom_wrap();
        while (exp_count != 0) gray_step(1'b0);
        gray_step(1'b0);
        check_all("R7");
        check("R7", "count after bottom wrap", count, 16'd5);
    endtask

    task automatic t_cnt_dir();
        drive(1'b0, 1'b1);
        mode = 1'b1;
        drive(1'b1, 1'b1);
        model_up();
        check_all("R4 rise up");
        drive(1'b0, 1'b1);
        check_all("R4 fall");
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        model_dn();
        check_all("R4 rise down");
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        model_dn();
        check_all("R4 second down");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_latency();
        t_phase_updown();
        t_invalid();
        t_top_wrap();
        t_clear();
        t_bottom_wrap();
        t_cnt_dir();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule